// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two two's-complement operands of parameterised width `WIDTH` over several clock cycles. A one-cycle `start` pulse latches the multiplicand and the multiplier. The block then retires one multiplier bit per clock. Each step looks at a pair of bits: the multiplier bit currently in the low position, and the bit that was shifted out of that position on the step before. The pair selects a subtraction of the multiplicand, an addition of it, or no arithmetic. After that the combined accumulator is shifted right by one place, with its sign bit copied into the top.

The multiplier occupies the low half of the combined product register, so no separate multiplier register exists. One extra flip-flop to the right of the low half holds the bit that was last shifted out. The only adder is a subtractor/adder that acts on the upper half. That adder is one bit wider than the operands, so the most negative multiplicand cannot overflow it. When the run ends, the signed product of width 2·`WIDTH` appears as a high word and a low word. It stays there until the next accepted `start`.

The controller is a three-state machine:
- **ST_IDLE**: waiting. A `start` seen here takes the *launch* transition to ST_STEP and loads the operands.
- **ST_STEP**: one recode/add/shift per cycle. The *keep* transition stays in ST_STEP. The *last-bit* transition goes to ST_DONE after the `WIDTH`th step.
- **ST_DONE**: holds `done` for one cycle. The *retire* transition always returns to ST_IDLE.

Top module: `booth_seq_mult`

## Requirements
- R1: After a run, {`prod_hi`,`prod_lo`} equals the signed product of the latched operands as a two's-complement value of 2·WIDTH bits. `prod_hi` carries bits 2·WIDTH-1 down to WIDTH, and `prod_lo` carries bits WIDTH-1 down to 0.
- R2: With WIDTH=4, 2 × 7 gives 8'h0E and 2 × (−3) gives 8'hFA.
- R3: The most negative operand value (−2^(WIDTH−1)) works as multiplicand, as multiplier, or as both, and gives the exact product.
- R4: `done` is high for exactly one cycle. It goes high after exactly WIDTH rising edges following the edge that samples `start`. Over that span exactly WIDTH recode/shift steps are performed.
- R5: `busy` is high from the edge that samples `start` through the cycle in which `done` is high, and low at all other times.
- R6: A `start` that arrives while `busy` is high is ignored. It does not restart the run and does not change the result.
- R7: The operands are latched on the edge that samples `start`. Changes to `mcand` or `mplier` after that edge do not affect the result.
- R8: While idle and without `start`, `prod_hi` and `prod_lo` keep their last values.
- R9: While `rst_n` is low, `busy`, `done`, `prod_hi` and `prod_lo` are all zero, and `start` is ignored.
- R10: A step whose bit pair is 00 or 11 changes the upper half only by the arithmetic right shift. Pair 01 adds the multiplicand before the shift, and pair 10 subtracts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a multiplication when the block is idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | WIDTH | Upper half of the signed product |
| prod_lo | output | WIDTH | Lower half of the signed product |

## Verification
The bench sweeps every operand pair at WIDTH=4, which includes −8 × −8 and −8 × 7. A design whose upper-half adder is only WIDTH bits wide would return a wrong sign or a wrapped product for those pairs. A shift that brings in zeros instead of the sign would corrupt every negative result. A wrong step count would misplace the product by a power of two and would move the `done` pulse.

During every run the bench also scrambles the operand inputs and holds `start` high into the busy period. A design that failed to latch the operands, or that restarted on a second `start`, would give products that do not match. A second instance at WIDTH=32 checks the extreme values and a pseudo-random set of operands against 64-bit arithmetic.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } booth_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_t op
);

    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   op = OP_SUB;   // a run of ones begins
            2'b01:   op = OP_ADD;   // a run of ones has ended
            default: op = OP_NONE;  // inside a run of zeros or of ones
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH-1:0] operand,
    input  booth_op_t        op,
    output logic [WIDTH:0]   result
);

    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] operand_ext;

    assign operand_ext = {operand[WIDTH-1], operand};

    always_comb begin
        unique case (op)
            OP_ADD:  result = acc + operand_ext;
            OP_SUB:  result = acc - operand_ext;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    booth_state_t state_q, state_d;
    logic [CW-1:0] count_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: launch, keep, last-bit, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_STEP;
            ST_STEP: if (count_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // step counter
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (load)  count_q <= '0;
        else if (step)  count_q <= count_q + 1'b1;
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_STEP: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count_q <= LAST));

    assert_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_q != LAST) |=> (step && count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);

    localparam int HW = WIDTH + 1;

    logic             load, step;
    logic [HW-1:0]    acc_q;      // upper half with one guard bit
    logic [WIDTH-1:0] low_q;      // multiplier, then low product bits
    logic             ext_q;      // bit shifted out on the previous step
    logic [WIDTH-1:0] mcand_q;
    logic [HW-1:0]    acc_next;
    booth_op_t        op;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .cur_bit  (low_q[0]),
        .prev_bit (ext_q),
        .op       (op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc     (acc_q),
        .operand (mcand_q),
        .op      (op),
        .result  (acc_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            low_q   <= '0;
            ext_q   <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            low_q   <= mplier;
            ext_q   <= 1'b0;
            mcand_q <= mcand;
        end else if (step) begin
            {acc_q, low_q, ext_q} <= {acc_next[WIDTH], acc_next, low_q};
        end
    end

    assign prod_hi = acc_q[WIDTH-1:0];
    assign prod_lo = low_q;

    assert_nop_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == OP_NONE) |=> acc_q == {$past(acc_q[WIDTH]), $past(acc_q[WIDTH:1])});

    assert_operands_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mcand_q));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));

    assert_guard_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_q[WIDTH] == acc_q[WIDTH-1]));

endmodule

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
module booth_seq_mult_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // narrow instance for the exhaustive sweep
    logic       start4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       busy4, done4;
    logic [3:0] hi4, lo4;

    booth_seq_mult #(.WIDTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start4), .mcand(a4), .mplier(b4),
        .busy(busy4), .done(done4), .prod_hi(hi4), .prod_lo(lo4)
    );

    // full-width instance
    logic        start32 = 1'b0;
    logic [31:0] a32 = '0, b32 = '0;
    logic        busy32, done32;
    logic [31:0] hi32, lo32;

    booth_seq_mult #(.WIDTH(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .start(start32), .mcand(a32), .mplier(b32),
        .busy(busy32), .done(done32), .prod_hi(hi32), .prod_lo(lo32)
    );

    logic [7:0] last4;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mul4(input logic [3:0] a, input logic [3:0] b);
        int p;
        int lat;
        logic [7:0] exp;
        p = int'($signed(a)) * int'($signed(b));
        exp = p[7:0];
        @(negedge clk);
        a4 = a; b4 = b; start4 = 1'b1;
        @(negedge clk);
        lat = 1;
        chk(busy4 == 1'b1, "R5 busy after start", 64'(busy4), 64'd1);
        a4 = ~a; b4 = ~b;          // R7: scramble after latch; R6: start stays high
        while (!done4 && lat < 50) begin
            @(negedge clk);
            if (lat == 1) start4 = 1'b0;
            lat++;
        end
        chk(lat == 5, "R4 latency", 64'(lat), 64'd5);
        last4 = {hi4, lo4};
        chk({hi4, lo4} == exp, "R1 R6 R7 product", 64'({hi4, lo4}), 64'(exp));
        @(negedge clk);
        chk(done4 == 1'b0 && busy4 == 1'b0, "R4 R5 pulse ends", 64'({done4, busy4}), 64'd0);
        @(negedge clk);
        chk({hi4, lo4} == exp, "R8 hold while idle", 64'({hi4, lo4}), 64'(exp));
    endtask

    task automatic mul32(input logic [31:0] a, input logic [31:0] b);
        longint p;
        int lat;
        p = longint'($signed(a)) * longint'($signed(b));
        @(negedge clk);
        a32 = a; b32 = b; start32 = 1'b1;
        @(negedge clk);
        start32 = 1'b0;
        a32 = b; b32 = a + 32'd1;
        lat = 1;
        while (!done32 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 33, "R4 latency 32", 64'(lat), 64'd33);
        chk({hi32, lo32} == 64'(p), "R1 R3 product 32", {hi32, lo32}, 64'(p));
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed_a, seed_b;
        // R9: reset state, start ignored during reset
        start4 = 1'b1; a4 = 4'd3; b4 = 4'd3;
        repeat (3) @(negedge clk);
        chk({busy4, done4, hi4, lo4} == 10'd0, "R9 reset state", 64'({busy4, done4, hi4, lo4}), 64'd0);
        start4 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy4, done4} == 2'd0, "R9 idle after reset", 64'({busy4, done4}), 64'd0);

        // R2 stated examples
        mul4(4'd2, 4'd7);
        chk(last4 == 8'h0E, "R2 2x7", 64'(last4), 64'h0E);
        mul4(4'd2, 4'hD);
        chk(last4 == 8'hFA, "R2 2x-3", 64'(last4), 64'hFA);

        // R3 most negative operand
        mul4(4'h8, 4'h8);
        chk(last4 == 8'h40, "R3 -8x-8", 64'(last4), 64'h40);
        mul4(4'h8, 4'h7);
        chk(last4 == 8'hC8, "R3 -8x7", 64'(last4), 64'hC8);

        // R1 R10 exhaustive sweep of all bit-pair patterns
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                mul4(4'(i), 4'(j));

        // full width
        mul32(32'h8000_0000, 32'h8000_0000);
        mul32(32'h8000_0000, 32'h7FFF_FFFF);
        mul32(32'h7FFF_FFFF, 32'h7FFF_FFFF);
        mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        mul32(32'h0000_0000, 32'hDEAD_BEEF);
        mul32(32'h5555_5555, 32'hAAAA_AAAA);
        seed_a = 32'h1234_5678;
        seed_b = 32'h9ABC_DEF1;
        for (int k = 0; k < 40; k++) begin
            seed_a = seed_a * 32'd1664525 + 32'd1013904223;
            seed_b = seed_b * 32'd22695477 + 32'd1;
            mul32(seed_a, seed_b);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule